// File: doc/BRIEF.md
# Interrupt CPU Interface Arbiter

This block is the processor-side end of an interrupt controller for a single processor. Every cycle it looks at all sources that are both enabled and pending and picks the most urgent one. A lower 8-bit priority value is more urgent, and on a tie the lower source number wins. The choice is then filtered twice. First it must pass a programmable priority mask. Second, it must be strictly more urgent than whatever the processor is already servicing. Only then is the single request line to the processor raised.

Software reaches the block through a small register port. Reading the acknowledge offset claims the chosen interrupt and makes it the running one. Writing an interrupt number to the end-of-interrupt offset retires it. Each claimed interrupt remembers which interrupt it preempted, so nested handlers unwind in order. An end-of-interrupt for an interrupt that is not the running one removes it from the middle of that chain. A small walker does this one link per clock and holds the port busy while it runs.

Sources arrive as level lines with a per-source enable, a per-source trigger type and a per-source priority. A global distribution enable is also an input.

Top module: `irq_cpu_if`

## Requirements
- R1: After reset, the control register (offset 0x00) reads 0 and the priority mask (offset 0x04) reads 0xF0. Running priority (offset 0x14) reads 0x100, highest pending (offset 0x18) reads 1023, and the request line is low.
- R2: Among enabled pending sources, the one with the smallest priority value is chosen; on equal values the lowest source number is chosen.
- R3: A candidate is reported as highest pending only if its priority is less than or equal to the mask. The request line is raised only if that priority is also strictly below the running priority.
- R4: When the distribution enable input or bit 0 of the control register is 0, the request line is low and highest pending reads 1023.
- R5: An acknowledge read (offset 0x0C) returns 1023 and changes nothing when there is no highest pending interrupt, or when its priority is not strictly below the running priority.
- R6: A successful acknowledge read returns the interrupt number, clears its pending bit, and makes it running with its own priority, saving the previous running number as its link.
- R7: An end-of-interrupt write (offset 0x10, number in bits 9:0) naming the running interrupt restores the running interrupt, and its priority, from that interrupt's link; the idle value 1023 gives running priority 0x100.
- R8: An end-of-interrupt write is ignored when the number is at or above the source count or when nothing is running.
- R9: An end-of-interrupt write naming a non-running interrupt leaves the running one in place and splices the named interrupt out of the preemption chain.
- R10: On a valid end-of-interrupt, a level-sensitive source (srcEdge bit 0) that is enabled and whose line is still high becomes pending again; its line staying high otherwise does not re-pend it.
- R11: A rising edge on a line sets pending for an edge source (srcEdge bit 1) even while disabled, and for a level source only while enabled.
- R12: While the chain walk runs, busy is high and register writes and acknowledge reads are ignored.
- R13: The highest pending value and the request line are registered: a pending bit set at one clock edge shows on the request line after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| distEnable | input | 1 | Global distribution enable |
| srcLevel | input | NUM_SRC | Interrupt input lines |
| srcEnable | input | NUM_SRC | Per-source enable |
| srcEdge | input | NUM_SRC | Per-source trigger type, 1 = edge, 0 = level |
| srcPrio | input | NUM_SRC*PRIO_W | Per-source priority, source i in bits i*PRIO_W upward |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (one cycle per read) |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 10 | Register write data |
| regRdata | output | 10 | Register read data, valid in the cycle of regRd |
| busy | output | 1 | Chain walk in progress |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
On every cycle, the assertions check four things. The request line never stands without a reported highest pending interrupt. Either enable being low forces the request off in the next cycle. A granted acknowledge always lowers the running priority. Nothing alters the running priority while the walk is busy or when an out-of-range end-of-interrupt is written. The winner selection is checked by the bench's scenarios against a reference model. So are tie-breaking, mask and running-priority boundaries, nested unwinding, splicing an interrupt out of the chain, level re-pending, and the one-cycle latency of the request line.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NO_IRQ = 10'h3FF;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_MASK = 8'h04;
  localparam logic [7:0] OFS_ACK  = 8'h0C;
  localparam logic [7:0] OFS_EOI  = 8'h10;
  localparam logic [7:0] OFS_RUNP = 8'h14;
  localparam logic [7:0] OFS_HPND = 8'h18;

  typedef enum logic {ST_IDLE, ST_WALK} walkSt_t;

  // strobes from control to datapath
  typedef struct packed {
    logic            ack;
    logic            eoiValid;
    logic            popRun;
    logic [ID_W-1:0] eoiId;
    logic            linkWr;
    logic [ID_W-1:0] linkIdx;
    logic [ID_W-1:0] linkVal;
    logic            ctrlWr;
    logic            ctrlVal;
    logic            maskWr;
    logic [7:0]      maskVal;
  } ctlStrobe_t;
endpackage

// File: rtl/irqarb_datapath.sv
module irqarb_datapath
  import irqarb_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      distEnable,
  input  logic [NUM_SRC-1:0]        srcLevel,
  input  logic [NUM_SRC-1:0]        srcEnable,
  input  logic [NUM_SRC-1:0]        srcEdge,
  input  logic [NUM_SRC*PRIO_W-1:0] srcPrio,
  input  ctlStrobe_t                stb,
  input  logic [ID_W-1:0]           linkIdxA,
  input  logic [ID_W-1:0]           linkIdxB,
  output logic [ID_W-1:0]           linkA,
  output logic [ID_W-1:0]           linkB,
  output logic [ID_W-1:0]           runId,
  output logic [PRIO_W:0]           runPrio,
  output logic [ID_W-1:0]           hpId,
  output logic [ID_W-1:0]           ackId,
  output logic                      cpuEn,
  output logic [PRIO_W-1:0]         prioMask,
  output logic                      irqOut
);
  localparam int LEAVES = 1 << $clog2(NUM_SRC);
  localparam int NODES  = 2 * LEAVES;
  localparam logic [PRIO_W:0] PRIO_NONE = {1'b1, {PRIO_W{1'b0}}};

  typedef struct packed {
    logic [PRIO_W:0] prio;
    logic [ID_W-1:0] id;
  } cand_t;

  logic [NUM_SRC-1:0] pending, pendNext, levelQ;
  logic [ID_W-1:0]    prevLink [NUM_SRC];
  cand_t              node [NODES];
  logic [PRIO_W:0]    hpPrio;
  logic               ackGrant;
  logic [ID_W-1:0]    popId;

  function automatic logic [PRIO_W:0] prioOf(input logic [ID_W-1:0] id);
    prioOf = PRIO_NONE;
    for (int i = 0; i < NUM_SRC; i++)
      if (id == ID_W'(i)) prioOf = {1'b0, srcPrio[i*PRIO_W +: PRIO_W]};
  endfunction

  function automatic logic [ID_W-1:0] linkOf(input logic [ID_W-1:0] id);
    linkOf = NO_IRQ;
    for (int i = 0; i < NUM_SRC; i++)
      if (id == ID_W'(i)) linkOf = prevLink[i];
  endfunction

  // comparison tree: leaves hold candidates, left child wins ties
  genvar g;
  for (g = 0; g < LEAVES; g++) begin : gLeaf
    if (g < NUM_SRC) begin : gReal
      assign node[LEAVES+g] = (srcEnable[g] && pending[g])
        ? '{prio: {1'b0, srcPrio[g*PRIO_W +: PRIO_W]}, id: ID_W'(g)}
        : '{prio: PRIO_NONE, id: NO_IRQ};
    end else begin : gPad
      assign node[LEAVES+g] = '{prio: PRIO_NONE, id: NO_IRQ};
    end
  end
  for (g = 1; g < LEAVES; g++) begin : gNode
    assign node[g] = (node[2*g+1].prio < node[2*g].prio) ? node[2*g+1] : node[2*g];
  end
  if (LEAVES > 1) begin : gRootFill
    assign node[0] = node[1];
  end else begin : gRootLeaf
    assign node[0] = '{prio: PRIO_NONE, id: NO_IRQ};
  end

  assign hpPrio   = prioOf(hpId);
  assign ackGrant = (hpId != NO_IRQ) && (hpPrio < runPrio);
  assign ackId    = ackGrant ? hpId : NO_IRQ;
  assign popId    = linkOf(runId);
  assign linkA    = linkOf(linkIdxA);
  assign linkB    = linkOf(linkIdxB);

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      logic riseSet, repend, clr;
      riseSet = srcLevel[i] && !levelQ[i] && (srcEdge[i] || srcEnable[i]);
      repend  = stb.eoiValid && (stb.eoiId == ID_W'(i)) && !srcEdge[i]
                && srcEnable[i] && srcLevel[i];
      clr     = stb.ack && ackGrant && (hpId == ID_W'(i));
      pendNext[i] = (pending[i] || riseSet || repend) && !clr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending  <= '0;
      levelQ   <= '0;
      cpuEn    <= 1'b0;
      prioMask <= PRIO_W'(8'hF0);
    end else begin
      pending <= pendNext;
      levelQ  <= srcLevel;
      if (stb.ctrlWr) cpuEn <= stb.ctrlVal;
      if (stb.maskWr) prioMask <= stb.maskVal[PRIO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SRC; i++) prevLink[i] <= NO_IRQ;
      runId   <= NO_IRQ;
      runPrio <= PRIO_NONE;
    end else begin
      if (stb.ack && ackGrant) begin
        runId   <= hpId;
        runPrio <= hpPrio;
        for (int i = 0; i < NUM_SRC; i++)
          if (hpId == ID_W'(i)) prevLink[i] <= runId;
      end else if (stb.popRun) begin
        runId   <= popId;
        runPrio <= prioOf(popId);
      end
      if (stb.linkWr)
        for (int i = 0; i < NUM_SRC; i++)
          if (stb.linkIdx == ID_W'(i)) prevLink[i] <= stb.linkVal;
    end
  end

  // registered winner and request line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hpId   <= NO_IRQ;
      irqOut <= 1'b0;
    end else if (!distEnable || !cpuEn || (node[1].prio > {1'b0, prioMask})) begin
      hpId   <= NO_IRQ;
      irqOut <= 1'b0;
    end else begin
      hpId   <= node[1].id;
      irqOut <= node[1].prio < runPrio;
    end
  end
endmodule

// File: rtl/irqarb_control.sv
module irqarb_control
  import irqarb_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [7:0]        regAddr,
  input  logic [ID_W-1:0]   regWdata,
  output logic [ID_W-1:0]   regRdata,
  input  logic [ID_W-1:0]   runId,
  input  logic [PRIO_W:0]   runPrio,
  input  logic [ID_W-1:0]   hpId,
  input  logic [ID_W-1:0]   ackId,
  input  logic              cpuEn,
  input  logic [PRIO_W-1:0] prioMask,
  input  logic [ID_W-1:0]   linkA,
  input  logic [ID_W-1:0]   linkB,
  output logic [ID_W-1:0]   linkIdxA,
  output logic [ID_W-1:0]   linkIdxB,
  output ctlStrobe_t        stb,
  output logic              busy
);
  walkSt_t         state;
  logic [ID_W-1:0] cursor, target;
  logic            startWalk, walkDone;

  assign busy     = (state == ST_WALK);
  assign linkIdxA = cursor;
  assign linkIdxB = target;

  always_comb begin
    stb = '0;
    startWalk = 1'b0;
    walkDone  = 1'b0;
    stb.ctrlVal = regWdata[0];
    stb.maskVal = regWdata[7:0];
    stb.eoiId   = regWdata;
    if (regWr && !busy) begin
      unique case (regAddr)
        OFS_CTRL: stb.ctrlWr = 1'b1;
        OFS_MASK: stb.maskWr = 1'b1;
        OFS_EOI: begin
          if ((32'(regWdata) < NUM_SRC) && (runId != NO_IRQ)) begin
            stb.eoiValid = 1'b1;
            if (regWdata == runId) stb.popRun = 1'b1;
            else                   startWalk  = 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (regRd && !busy && (regAddr == OFS_ACK)) stb.ack = 1'b1;
    if (busy) begin
      if (linkA == NO_IRQ) begin
        walkDone = 1'b1;
      end else if (linkA == target) begin
        walkDone    = 1'b1;
        stb.linkWr  = 1'b1;
        stb.linkIdx = cursor;
        stb.linkVal = linkB;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cursor <= NO_IRQ;
      target <= NO_IRQ;
    end else if (state == ST_IDLE) begin
      if (startWalk) begin
        state  <= ST_WALK;
        cursor <= runId;
        target <= regWdata;
      end
    end else begin
      if (walkDone) state <= ST_IDLE;
      else          cursor <= linkA;
    end
  end

  always_comb begin
    unique case (regAddr)
      OFS_CTRL: regRdata = ID_W'(cpuEn);
      OFS_MASK: regRdata = ID_W'(prioMask);
      OFS_ACK:  regRdata = busy ? NO_IRQ : ackId;
      OFS_RUNP: regRdata = ID_W'(runPrio);
      OFS_HPND: regRdata = hpId;
      default:  regRdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if
  import irqarb_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      distEnable,
  input  logic [NUM_SRC-1:0]        srcLevel,
  input  logic [NUM_SRC-1:0]        srcEnable,
  input  logic [NUM_SRC-1:0]        srcEdge,
  input  logic [NUM_SRC*PRIO_W-1:0] srcPrio,
  input  logic                      regWr,
  input  logic                      regRd,
  input  logic [7:0]                regAddr,
  input  logic [9:0]                regWdata,
  output logic [9:0]                regRdata,
  output logic                      busy,
  output logic                      irqOut
);
  ctlStrobe_t        stb;
  logic [ID_W-1:0]   runId, hpId, ackId, linkA, linkB, linkIdxA, linkIdxB;
  logic [PRIO_W:0]   runPrio;
  logic              cpuEn;
  logic [PRIO_W-1:0] prioMask;

  irqarb_control #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_ctl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .runId(runId), .runPrio(runPrio),
    .hpId(hpId), .ackId(ackId), .cpuEn(cpuEn), .prioMask(prioMask),
    .linkA(linkA), .linkB(linkB), .linkIdxA(linkIdxA), .linkIdxB(linkIdxB),
    .stb(stb), .busy(busy)
  );

  irqarb_datapath #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_dp (
    .clk(clk), .rstN(rstN), .distEnable(distEnable), .srcLevel(srcLevel),
    .srcEnable(srcEnable), .srcEdge(srcEdge), .srcPrio(srcPrio), .stb(stb),
    .linkIdxA(linkIdxA), .linkIdxB(linkIdxB), .linkA(linkA), .linkB(linkB),
    .runId(runId), .runPrio(runPrio), .hpId(hpId), .ackId(ackId),
    .cpuEn(cpuEn), .prioMask(prioMask), .irqOut(irqOut)
  );
endmodule

// File: rtl/irqarb_checker.sv
module irqarb_checker #(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            distEnable,
  input logic            cpuEn,
  input logic            regWr,
  input logic            regRd,
  input logic [7:0]      regAddr,
  input logic [9:0]      regWdata,
  input logic [9:0]      regRdata,
  input logic            busy,
  input logic            irqOut,
  input logic [9:0]      hpId,
  input logic [PRIO_W:0] runPrio
);
  a_r3_irq_needs_pending: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (hpId != 10'h3FF));

  a_r4_enable_gate: assert property (@(posedge clk) disable iff (!rstN)
    (!distEnable || !cpuEn) |=> (!irqOut && hpId == 10'h3FF));

  a_r6_ack_lowers_run: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && !busy && regAddr == 8'h0C && regRdata != 10'h3FF)
      |=> (runPrio < $past(runPrio)));

  a_r8_eoi_range: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && !busy && regAddr == 8'h10 && 32'(regWdata) >= NUM_SRC)
      |=> (runPrio == $past(runPrio) && !busy));

  a_r12_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (runPrio == $past(runPrio)));
endmodule

bind irq_cpu_if irqarb_checker #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rstN(rstN), .distEnable(distEnable), .cpuEn(cpuEn),
  .regWr(regWr), .regRd(regRd), .regAddr(regAddr), .regWdata(regWdata),
  .regRdata(regRdata), .busy(busy), .irqOut(irqOut), .hpId(hpId),
  .runPrio(runPrio)
);

// File: tb/sim_irq_cpu_if.sv
`timescale 1ns/1ps
module sim_irq_cpu_if;
  localparam int N = 16;
  localparam logic [7:0] A_CTRL = 8'h00, A_MASK = 8'h04, A_ACK = 8'h0C,
                         A_EOI = 8'h10, A_RUNP = 8'h14, A_HPND = 8'h18;

  logic clk = 0, rstN = 0, distEnable = 0;
  logic [N-1:0] lvl = '0, en = '0, edg = '0;
  logic [N*8-1:0] prio = '0;
  logic regWr = 0, regRd = 0;
  logic [7:0] regAddr = '0;
  logic [9:0] regWdata = '0;
  logic [9:0] regRdata;
  logic busy, irqOut;
  int checks = 0, errs = 0;
  logic [31:0] d;
  logic [N-1:0] pendM;

  always #10 clk = ~clk;

  irq_cpu_if #(.NUM_SRC(N), .PRIO_W(8)) u0 (
    .clk(clk), .rstN(rstN), .distEnable(distEnable), .srcLevel(lvl),
    .srcEnable(en), .srcEdge(edg), .srcPrio(prio), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .busy(busy), .irqOut(irqOut));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [9:0] v);
    @(negedge clk); regWr = 1; regAddr = a; regWdata = v;
    @(posedge clk); #1 regWr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); regRd = 1; regAddr = a;
    #1 v = 32'(regRdata);
    @(posedge clk); #1 regRd = 0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic pulse(input int id);
    @(negedge clk); lvl[id] = 1;
    @(negedge clk); lvl[id] = 0;
  endtask

  task automatic setPrio(input int id, input logic [7:0] v);
    prio[id*8 +: 8] = v;
  endtask

  function automatic int bestOf(input logic [N-1:0] p, input logic [N-1:0] e,
                                input logic [N*8-1:0] pr);
    int bi = 1023;
    int bp = 256;
    for (int i = 0; i < N; i++)
      if (p[i] && e[i] && int'(pr[i*8 +: 8]) < bp) begin
        bp = int'(pr[i*8 +: 8]);
        bi = i;
      end
    return bi;
  endfunction

  initial begin
    #(20 * 150000);
    errs++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) setPrio(i, 8'h80);
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1;
    #1;
    // R1 reset state
    rd(A_CTRL, d); chk("R1 ctrl", d, 0);
    rd(A_MASK, d); chk("R1 mask", d, 'hF0);
    rd(A_RUNP, d); chk("R1 runprio", d, 'h100);
    rd(A_HPND, d); chk("R1 hpend", d, 1023);
    chk("R1 irq", irqOut, 0);

    distEnable = 1; edg = '1; en = '1;
    wr(A_CTRL, 1); wr(A_MASK, 'hFF);

    // R13 latency
    setPrio(3, 8'h40);
    @(negedge clk); lvl[3] = 1;
    @(posedge clk); #1 chk("R13 irq after first edge", irqOut, 0);
    @(posedge clk); #1 chk("R13 irq after second edge", irqOut, 1);
    lvl[3] = 0;
    settle();

    // R6 acknowledge
    rd(A_ACK, d); chk("R6 ack id", d, 3);
    settle();
    rd(A_RUNP, d); chk("R6 runprio", d, 'h40);
    rd(A_HPND, d); chk("R6 pending cleared", d, 1023);
    chk("R6 irq low", irqOut, 0);

    // R8 out of range
    wr(A_EOI, 10'h3FF); settle();
    rd(A_RUNP, d); chk("R8 eoi 1023 ignored", d, 'h40);
    wr(A_EOI, 10'd16); settle();
    rd(A_RUNP, d); chk("R8 eoi 16 ignored", d, 'h40);

    // R7 retire running
    wr(A_EOI, 3); settle();
    rd(A_RUNP, d); chk("R7 back to idle", d, 'h100);
    wr(A_EOI, 3); settle();
    rd(A_RUNP, d); chk("R8 eoi when idle", d, 'h100);
    chk("R8 not busy", busy, 0);

    // R5 nothing to acknowledge
    rd(A_ACK, d); chk("R5 ack empty", d, 1023);
    rd(A_RUNP, d); chk("R5 runprio kept", d, 'h100);

    // R2 tie
    setPrio(6, 8'h30); setPrio(9, 8'h30);
    @(negedge clk); lvl[6] = 1; lvl[9] = 1;
    @(negedge clk); lvl[6] = 0; lvl[9] = 0;
    settle();
    rd(A_HPND, d); chk("R2 tie lower id", d, 6);
    rd(A_ACK, d); wr(A_EOI, 6); settle();
    rd(A_HPND, d); chk("R2 next after tie", d, 9);
    rd(A_ACK, d); wr(A_EOI, 9); settle();

    // R3 mask and running priority
    setPrio(4, 8'h50); setPrio(7, 8'h50);
    wr(A_MASK, 'h4F); pulse(4); settle();
    rd(A_HPND, d); chk("R3 masked out", d, 1023);
    chk("R3 masked irq", irqOut, 0);
    wr(A_MASK, 'h50); settle();
    rd(A_HPND, d); chk("R3 mask equal passes", d, 4);
    chk("R3 irq raised", irqOut, 1);
    rd(A_ACK, d); pulse(7); settle();
    rd(A_HPND, d); chk("R3 equal to running still reported", d, 7);
    chk("R3 equal to running no irq", irqOut, 0);
    rd(A_ACK, d); chk("R5 ack not above running", d, 1023);
    wr(A_EOI, 4); settle();
    chk("R3 irq after retire", irqOut, 1);
    rd(A_ACK, d); wr(A_EOI, 7); settle();

    // R4 enables
    pulse(4); settle();
    chk("R4 irq before", irqOut, 1);
    distEnable = 0; settle();
    chk("R4 dist off irq", irqOut, 0);
    rd(A_HPND, d); chk("R4 dist off hpend", d, 1023);
    distEnable = 1; wr(A_CTRL, 0); settle();
    chk("R4 cpu off irq", irqOut, 0);
    rd(A_HPND, d); chk("R4 cpu off hpend", d, 1023);
    wr(A_CTRL, 1); settle();
    rd(A_HPND, d); chk("R4 restored", d, 4);
    rd(A_ACK, d); wr(A_EOI, 4); wr(A_MASK, 'hFF); settle();

    // R11 triggers while disabled
    setPrio(8, 8'h20); en[8] = 0; pulse(8); settle();
    rd(A_HPND, d); chk("R11 disabled edge hidden", d, 1023);
    en[8] = 1; settle();
    rd(A_HPND, d); chk("R11 edge pended while disabled", d, 8);
    rd(A_ACK, d); wr(A_EOI, 8);
    edg[10] = 0; en[10] = 0; pulse(10); settle();
    en[10] = 1; settle();
    rd(A_HPND, d); chk("R11 level not pended while disabled", d, 1023);

    // R10 level re-pend
    edg[5] = 0; setPrio(5, 8'h60);
    @(negedge clk); lvl[5] = 1;
    settle();
    rd(A_HPND, d); chk("R10 level pends", d, 5);
    rd(A_ACK, d); settle();
    rd(A_HPND, d); chk("R10 held high no re-pend", d, 1023);
    wr(A_EOI, 5); settle();
    rd(A_HPND, d); chk("R10 re-pend at eoi", d, 5);
    @(negedge clk); lvl[5] = 0;
    rd(A_ACK, d); wr(A_EOI, 5); settle();
    rd(A_HPND, d); chk("R10 low no re-pend", d, 1023);

    // R9 / R12 chain splice
    setPrio(11, 8'h80); setPrio(12, 8'h40); setPrio(13, 8'h20);
    pulse(11); settle(); rd(A_ACK, d);
    pulse(12); settle(); rd(A_ACK, d);
    pulse(13); settle(); rd(A_ACK, d);
    rd(A_RUNP, d); chk("R9 nested running", d, 'h20);
    wr(A_EOI, 11);
    chk("R12 busy during walk", busy, 1);
    wr(A_MASK, 'h10);
    settle();
    rd(A_MASK, d); chk("R12 write ignored while busy", d, 'hFF);
    rd(A_RUNP, d); chk("R9 running unchanged", d, 'h20);
    wr(A_EOI, 13); settle();
    rd(A_RUNP, d); chk("R9 unwind to middle", d, 'h40);
    wr(A_EOI, 12); settle();
    rd(A_RUNP, d); chk("R9 spliced entry skipped", d, 'h100);

    // R2 random priorities against the model
    edg = '1; pendM = '0;
    for (int it = 0; it < 30; it++) begin
      logic [N-1:0] sub;
      for (int i = 0; i < N; i++) setPrio(i, 8'($urandom % 256));
      en  = N'($urandom);
      sub = N'($urandom);
      @(negedge clk); lvl = sub;
      @(negedge clk); lvl = '0;
      pendM |= sub;
      settle();
      rd(A_HPND, d); chk("R2 random winner", d, bestOf(pendM, en, prio));
      en = '1; settle();
      for (int k = 0; k < N + 1; k++) begin
        int exp;
        rd(A_HPND, d);
        if (d == 1023) break;
        exp = bestOf(pendM, en, prio);
        rd(A_ACK, d); chk("R6 random ack", d, exp);
        if (d < N) pendM[d] = 1'b0;
        wr(A_EOI, d[9:0]); settle();
      end
      rd(A_HPND, d); chk("R2 drained", d, 1023);
      pendM = '0;
    end

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule